// File: doc/BRIEF.md
# DMA Stop Status Register

This block keeps one sticky flag per DMA channel. A flag marks a transfer that ended early because the channel's peripheral asked the DMA to stop. Software reads and clears the flags through one 8-bit register location. A half-select input chooses which byte of the 16-bit flag vector that location shows.

A stop request only counts while a transfer is running on that channel. The request is taken on its rising edge. A stop that lands on the final transfer of a block does not set a flag, because the block ran to its end. When the channel's stop-enable control is set, an accepted stop also sends a one-cycle clear strobe to that channel's DMA enable bit. Only channel 12 has a stop source wired up. The other channels' stop inputs are ignored, but their flags still exist.

Top module: `dma_stop_status`

## Requirements
- R1: While `rst_ni` is low, every status flag and every enable-clear strobe is 0.
- R2: `reg_rdata_o` follows `half_sel_i` combinationally. Select value 0 shows flags 15..8 and select value 1 shows flags 7..0, with bit n of the byte being flag 8*k+n.
- R3: A stop request is accepted in the cycle its input is first sampled high while that channel's transfer-active input is high. If the last-transfer input is low in that cycle, the channel's flag reads 1 after that clock edge.
- R4: A stop request accepted while the channel's last-transfer input is high leaves the flag unchanged.
- R5: A stop request while the channel's transfer-active input is low changes neither the flag nor the enable-clear strobe.
- R6: A write (`reg_wr_i` high at a clock edge) clears each flag of the selected byte whose data bit is 0, and leaves each flag whose data bit is 1 unchanged. The byte that is not selected is not changed.
- R7: When a flag's set event and a write that would clear it fall on the same clock edge, the flag reads 1 afterwards.
- R8: An accepted stop on a channel whose stop-enable input is 1 drives that channel's `en_clr_o` bit high for exactly the following cycle, whether or not it is the last transfer. With stop-enable 0 the strobe stays low.
- R9: A stop request held high for several cycles is accepted once. It gives a single strobe and a single set event.
- R10: Stop inputs of channels without a connected source (every channel except 12 by default) have no effect. Those flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_i | input | 16 | Stop request per channel from its peripheral |
| xfer_active_i | input | 16 | Transfer in progress, per channel |
| xfer_last_i | input | 16 | Current transfer is the last of the block, per channel |
| stop_en_i | input | 16 | Stop-enable control per channel |
| half_sel_i | input | 1 | Byte select: 0 = flags 15..8, 1 = flags 7..0 |
| reg_wr_i | input | 1 | CPU write strobe |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | CPU read data for the selected byte |
| status_o | output | 16 | Stop status flags |
| en_clr_o | output | 16 | One-cycle clear strobe to each channel's DMA enable bit |

## Verification
The bench drives a stop on the last transfer. A design that dropped the last-transfer qualifier would set the flag, while the enable strobe must still appear. It writes 0 on the same edge as a new stop event, so a design that gave the write priority would lose the event. It holds a request high across several cycles, which exposes level-sensitive acceptance as repeated strobes. It also writes each byte half on its own and pulses stop on an unwired channel. A design with a swapped or merged byte decode would corrupt the other half, and one that lacked the source mask would set a flag that must stay 0.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned DSS_NCH    = 16;
  localparam int unsigned DSS_BYTE_W = 8;
  localparam logic [DSS_NCH-1:0] DSS_SRC_MASK = 16'h1000;
endpackage

// File: rtl/dss_stop_detect.sv
module dss_stop_detect #(
  parameter int unsigned        NCH      = dss_pkg::DSS_NCH,
  parameter logic [NCH-1:0]     SRC_MASK = dss_pkg::DSS_SRC_MASK
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] stop_req_i,
  input  logic [NCH-1:0] xfer_active_i,
  input  logic [NCH-1:0] xfer_last_i,
  output logic [NCH-1:0] accept_o,
  output logic [NCH-1:0] record_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (SRC_MASK[c]) begin : g_src
      logic req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= stop_req_i[c];
      end
      // rising edge of request, only while the channel is transferring
      assign accept_o[c] = stop_req_i[c] & ~req_q & xfer_active_i[c];
      assign record_o[c] = accept_o[c] & ~xfer_last_i[c];
    end else begin : g_nosrc
      assign accept_o[c] = 1'b0;
      assign record_o[c] = 1'b0;
    end
  end
endmodule

// File: rtl/dss_status_bits.sv
module dss_status_bits #(
  parameter int unsigned NCH = dss_pkg::DSS_NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] wr_mask_i,
  input  logic [NCH-1:0] wr_data_i,
  output logic [NCH-1:0] status_o
);
  logic [NCH-1:0] clr;
  logic [NCH-1:0] status_d;

  assign clr = wr_mask_i & ~wr_data_i;

  // set wins over a same-cycle clear
  always_comb status_d = set_i | (status_o & ~clr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_d;
  end
endmodule

// File: rtl/dss_byte_port.sv
module dss_byte_port #(
  parameter int unsigned NCH    = dss_pkg::DSS_NCH,
  parameter int unsigned BYTE_W = dss_pkg::DSS_BYTE_W,
  localparam int unsigned NBYTE = NCH / BYTE_W,
  localparam int unsigned SEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NCH-1:0]    status_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NCH-1:0]    wr_mask_o,
  output logic [NCH-1:0]    wr_data_o
);
  logic [NBYTE-1:0]  hit;
  logic [BYTE_W-1:0] part [NBYTE];

  // select 0 addresses the most significant byte
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    localparam logic [SEL_W-1:0] CODE = SEL_W'(NBYTE - 1 - b);
    assign hit[b] = (sel_i == CODE);
    assign part[b] = hit[b] ? status_i[b*BYTE_W +: BYTE_W] : '0;
    assign wr_mask_o[b*BYTE_W +: BYTE_W] = {BYTE_W{wr_i & hit[b]}};
    assign wr_data_o[b*BYTE_W +: BYTE_W] = wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < int'(NBYTE); b++) rdata_o = rdata_o | part[b];
  end
endmodule

// File: rtl/dss_clr_pulse.sv
module dss_clr_pulse #(
  parameter int unsigned NCH = dss_pkg::DSS_NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] accept_i,
  input  logic [NCH-1:0] stop_en_i,
  output logic [NCH-1:0] en_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_clr_o <= '0;
    else         en_clr_o <= accept_i & stop_en_i;
  end
endmodule

// File: rtl/dma_stop_status.sv
module dma_stop_status #(
  parameter int unsigned    NCH      = dss_pkg::DSS_NCH,
  parameter int unsigned    BYTE_W   = dss_pkg::DSS_BYTE_W,
  parameter logic [NCH-1:0] SRC_MASK = dss_pkg::DSS_SRC_MASK,
  localparam int unsigned   NBYTE    = NCH / BYTE_W,
  localparam int unsigned   SEL_W    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    stop_req_i,
  input  logic [NCH-1:0]    xfer_active_i,
  input  logic [NCH-1:0]    xfer_last_i,
  input  logic [NCH-1:0]    stop_en_i,
  input  logic [SEL_W-1:0]  half_sel_i,
  input  logic              reg_wr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic [NCH-1:0]    status_o,
  output logic [NCH-1:0]    en_clr_o
);
  logic [NCH-1:0] accept;
  logic [NCH-1:0] record;
  logic [NCH-1:0] wr_mask;
  logic [NCH-1:0] wr_data;

  dss_stop_detect #(.NCH(NCH), .SRC_MASK(SRC_MASK)) u_detect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_req_i    (stop_req_i),
    .xfer_active_i (xfer_active_i),
    .xfer_last_i   (xfer_last_i),
    .accept_o      (accept),
    .record_o      (record)
  );

  dss_byte_port #(.NCH(NCH), .BYTE_W(BYTE_W)) u_port (
    .sel_i     (half_sel_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (status_o),
    .rdata_o   (reg_rdata_o),
    .wr_mask_o (wr_mask),
    .wr_data_o (wr_data)
  );

  dss_status_bits #(.NCH(NCH)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (record),
    .wr_mask_i (wr_mask),
    .wr_data_i (wr_data),
    .status_o  (status_o)
  );

  dss_clr_pulse #(.NCH(NCH)) u_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .stop_en_i (stop_en_i),
    .en_clr_o  (en_clr_o)
  );
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int unsigned    NCH      = dss_pkg::DSS_NCH,
  parameter logic [NCH-1:0] SRC_MASK = dss_pkg::DSS_SRC_MASK
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] xfer_active_i,
  input logic [NCH-1:0] xfer_last_i,
  input logic [NCH-1:0] stop_en_i,
  input logic [NCH-1:0] status_o,
  input logic [NCH-1:0] en_clr_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (status_o == '0 && en_clr_o == '0));

  p_no_rise_on_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o) & $past(xfer_last_i)) == '0));

  p_no_rise_when_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o) & ~$past(xfer_active_i)) == '0));

  p_clr_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_clr_o & ~$past(stop_en_i)) == '0));

  p_clr_single_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_clr_o & $past(en_clr_o)) == '0));

  p_unwired_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~SRC_MASK) == '0 && (en_clr_o & ~SRC_MASK) == '0));
endmodule

bind dma_stop_status dss_checker #(.NCH(NCH), .SRC_MASK(SRC_MASK)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .xfer_active_i (xfer_active_i),
  .xfer_last_i   (xfer_last_i),
  .stop_en_i     (stop_en_i),
  .status_o      (status_o),
  .en_clr_o      (en_clr_o)
);

// File: tb/dma_stop_status_tb_top.sv
module dma_stop_status_tb_top;
  localparam int CH = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] stop_req_i = '0;
  logic [15:0] xfer_active_i = '0;
  logic [15:0] xfer_last_i = '0;
  logic [15:0] stop_en_i = '0;
  logic [0:0]  half_sel_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] status_o;
  logic [15:0] en_clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  dma_stop_status dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .stop_req_i (stop_req_i), .xfer_active_i (xfer_active_i),
    .xfer_last_i (xfer_last_i), .stop_en_i (stop_en_i),
    .half_sel_i (half_sel_i), .reg_wr_i (reg_wr_i),
    .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o),
    .status_o (status_o), .en_clr_o (en_clr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic rd(input bit sel, output logic [7:0] d);
    @(negedge clk_i); half_sel_i = sel; #1; d = reg_rdata_o;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk_i); half_sel_i = sel; reg_wr_i = 1'b1; reg_wdata_i = d;
    tick();
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  // one-cycle stop pulse on a channel, then check strobe fall
  task automatic stop_pulse(input int c, input bit act, input bit last, input bit en,
                            input logic [15:0] exp_st, input logic [15:0] exp_clr,
                            input string req);
    @(negedge clk_i);
    xfer_active_i[c] = act; xfer_last_i[c] = last; stop_en_i[c] = en; stop_req_i[c] = 1'b1;
    tick();
    chk({req, " status"}, status_o, exp_st);
    chk({req, " en_clr"}, en_clr_o, exp_clr);
    @(negedge clk_i); stop_req_i[c] = 1'b0;
    tick();
    chk({req, " en_clr drop"}, en_clr_o, '0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 status", status_o, '0);
    chk("R1 en_clr", en_clr_o, '0);
    rd(1'b0, d); chk("R1 upper byte", d, 8'h00);
    rd(1'b1, d); chk("R1 lower byte", d, 8'h00);
  endtask

  task automatic t_set_and_read();
    logic [7:0] d;
    stop_pulse(CH, 1'b1, 1'b0, 1'b0, 16'h1000, 16'h0000, "R3 set no-enable");
    rd(1'b0, d); chk("R2 upper byte shows flag 12", d, 8'h10);
    rd(1'b1, d); chk("R2 lower byte", d, 8'h00);
  endtask

  task automatic t_write_semantics();
    logic [7:0] d;
    wr(1'b0, 8'hFF); chk("R6 write one keeps", status_o, 16'h1000);
    wr(1'b1, 8'h00); chk("R6 other byte untouched", status_o, 16'h1000);
    wr(1'b0, 8'hEF); chk("R6 write zero clears", status_o, 16'h0000);
    rd(1'b0, d);     chk("R2 upper after clear", d, 8'h00);
  endtask

  task automatic t_last_transfer();
    stop_pulse(CH, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h1000, "R4 last no set, R8 strobe");
  endtask

  task automatic t_inactive();
    stop_pulse(CH, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, "R5 idle");
  endtask

  task automatic t_enable_strobe();
    stop_pulse(CH, 1'b1, 1'b0, 1'b1, 16'h1000, 16'h1000, "R8 strobe");
  endtask

  task automatic t_set_beats_clear();
    // flag is 1 from previous task; new event on the same edge as a clearing write
    @(negedge clk_i);
    xfer_active_i[CH] = 1'b1; xfer_last_i[CH] = 1'b0; stop_en_i[CH] = 1'b0;
    stop_req_i[CH] = 1'b1; half_sel_i = 1'b0; reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
    tick();
    chk("R7 set beats clear", status_o, 16'h1000);
    @(negedge clk_i); reg_wr_i = 1'b0; stop_req_i[CH] = 1'b0;
    tick();
    wr(1'b0, 8'h00);
    chk("R6 cleared for next test", status_o, 16'h0000);
  endtask

  task automatic t_held_request();
    int pulses = 0;
    logic [15:0] st_seen = '0;
    @(negedge clk_i);
    xfer_active_i[CH] = 1'b1; xfer_last_i[CH] = 1'b0; stop_en_i[CH] = 1'b1; stop_req_i[CH] = 1'b1;
    tick();
    st_seen = status_o;
    for (int i = 0; i < 6; i++) begin
      if (en_clr_o[CH]) pulses++;
      if (i == 2) begin
        @(negedge clk_i); half_sel_i = 1'b0; reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
      end
      if (i == 3) begin
        @(negedge clk_i); reg_wr_i = 1'b0;
      end
      tick();
    end
    chk("R9 single strobe", pulses, 1);
    chk("R9 first set", st_seen, 16'h1000);
    chk("R9 no re-set while held", status_o, 16'h0000);
    @(negedge clk_i); stop_req_i[CH] = 1'b0;
    tick();
  endtask

  task automatic t_unwired();
    stop_pulse(5, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0000, "R10 ch5 ignored");
    stop_pulse(13, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0000, "R10 ch13 ignored");
  endtask

  initial begin
    #1;
    chk("R1 in reset", {status_o, en_clr_o}, '0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    t_reset();
    t_set_and_read();
    t_write_semantics();
    t_last_transfer();
    t_inactive();
    t_enable_strobe();
    t_set_beats_clear();
    t_held_request();
    t_unwired();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule